// File: doc/BRIEF.md
# Cycle-Stepped Clock Gate for Lockstep Co-Simulation

This block lets a host computer hold a fully synchronous design under test in lockstep with a software model of its surroundings. The design's clock is never stopped. Instead, the block drives a clock-enable, `dut_en`, that the design's registers honour. The enable is raised only for a burst of cycles that the host has granted. When the burst ends, the enable drops and the design stays frozen.

Each iteration runs in a fixed order:
1. The host samples the design's outputs.
2. The host writes fresh inputs.
3. The host programs a cycle count and issues a go command.
4. The host polls until the burst completes, then repeats or stops.

Because the design is purely synchronous, pausing it between bursts does not change its behaviour.

The host reaches the block through a small word-wide register port. The block has four registers:
- a step-length register;
- a go command;
- a status word with busy and complete flags;
- a running count of every enabled cycle since reset.

All of them share the same bus as the registers that carry the design's own inputs and outputs.

Top module: `sync_step_top`

## Requirements
- R1: After reset, `dut_en` is low, the status word reads 0, the enabled-cycle count reads 0 and the step-length register reads 0.
- R2: A write to address 0 stores the low CNT_W bits of the data as the step length, and a read of address 0 returns that value zero-extended.
- R3: A write to address 1 with data bit 0 set, while idle and with a nonzero step length N, raises `dut_en` from the next cycle for exactly N consecutive cycles.
- R4: Status (address 2) bit 0 is the busy flag and reads 1 exactly while a burst is in progress.
- R5: Status bit 1 is the complete flag. It becomes 1 on the edge that ends a burst, stays 1 while idle, and is cleared by the edge that accepts the next go command.
- R6: A go command with a step length of 0 is ignored: `dut_en` stays low and the complete flag keeps its value.
- R7: A go command that arrives during a burst is ignored, and the running burst keeps its original length.
- R8: The TOT_W-bit count at address 3 increases by one on every cycle in which `dut_en` is high, and holds otherwise.
- R9: A write to address 1 with data bit 0 clear starts nothing.
- R10: Rewriting the step length during a burst does not change that burst. The new value is used by the next accepted go command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock shared with the design under test |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, sampled on the rising edge |
| host_addr | input | 2 | Register select for both writes and reads |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Combinational read data for `host_addr` |
| dut_en | output | 1 | Clock enable for the design under test |

## Verification
The bench builds the block with CNT_W = 8, TOT_W = 32 and DATA_W = 32. The narrow step register puts the longest possible burst (255 cycles) within cheap reach, and the bench runs that burst to its exact end. The full-width count is read back after every burst of the vector table, so any lost or extra enabled cycle shows up in the running total. Directed cases cover the ignored commands (zero length, busy, bit 0 clear) and a step rewrite during a burst.

// File: rtl/sync_step_pkg.sv
package sync_step_pkg;

    typedef enum logic [1:0] {
        REG_STEP  = 2'd0,
        REG_CMD   = 2'd1,
        REG_STAT  = 2'd2,
        REG_TOTAL = 2'd3
    } host_reg_e;

    localparam int CMD_GO_BIT    = 0;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 1;

endpackage

// File: rtl/sync_step_regs.sv
module sync_step_regs
    import sync_step_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TOT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [TOT_W-1:0]  total,
    output logic              start_req,
    output logic [CNT_W-1:0]  step_val,
    output logic [DATA_W-1:0] host_rdata
);

    typedef struct packed {
        logic [CNT_W-1:0] step;
    } regs_t;

    regs_t     regs_d, regs_q;
    host_reg_e sel;

    assign sel = host_reg_e'(host_addr);

    always_comb begin
        regs_d     = regs_q;
        start_req  = 1'b0;
        host_rdata = '0;

        // host write decode
        if (host_wr) begin
            case (sel)
                REG_STEP: regs_d.step = host_wdata[CNT_W-1:0];
                REG_CMD:  start_req   = host_wdata[CMD_GO_BIT];
                default:  ;
            endcase
        end

        // host read mux
        case (sel)
            REG_STEP:  host_rdata = DATA_W'(regs_q.step);
            REG_STAT: begin
                host_rdata[STAT_BUSY_BIT] = busy;
                host_rdata[STAT_DONE_BIT] = done;
            end
            REG_TOTAL: host_rdata = DATA_W'(total);
            default:   host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign step_val = regs_q.step;

endmodule

// File: rtl/sync_step_burst.sv
module sync_step_burst #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [CNT_W-1:0] step_val,
    output logic             run_en,
    output logic [CNT_W-1:0] remain,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            // running: commands are ignored
            st_d.cnt = st_q.cnt - ONE;
            if (st_q.cnt == ONE) st_d.done = 1'b1;
        end else if (start_req && (step_val != '0)) begin
            st_d.cnt  = step_val;
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_en = (st_q.cnt != '0);
    assign remain = st_q.cnt;
    assign done   = st_q.done;

endmodule

// File: rtl/sync_step_tally.sv
module sync_step_tally #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [TOT_W-1:0] total
);

    typedef struct packed {
        logic [TOT_W-1:0] count;
    } tally_t;

    tally_t tl_d, tl_q;

    always_comb begin
        tl_d = tl_q;
        if (tick) tl_d.count = tl_q.count + TOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tl_q <= '0;
        else        tl_q <= tl_d;
    end

    assign total = tl_q.count;

endmodule

// File: rtl/sync_step_top.sv
module sync_step_top #(
    parameter int CNT_W  = 16,
    parameter int TOT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dut_en
);

    logic             start_req;
    logic [CNT_W-1:0] step_val;
    logic [CNT_W-1:0] remain;
    logic             done;
    logic [TOT_W-1:0] total;

    sync_step_regs #(
        .CNT_W (CNT_W),
        .TOT_W (TOT_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .busy      (dut_en),
        .done      (done),
        .total     (total),
        .start_req (start_req),
        .step_val  (step_val),
        .host_rdata(host_rdata)
    );

    sync_step_burst #(
        .CNT_W(CNT_W)
    ) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_req(start_req),
        .step_val (step_val),
        .run_en   (dut_en),
        .remain   (remain),
        .done     (done)
    );

    sync_step_tally #(
        .TOT_W(TOT_W)
    ) u_tally (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (dut_en),
        .total(total)
    );

endmodule

// File: rtl/sync_step_chk.sv
module sync_step_chk #(
    parameter int CNT_W = 16,
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dut_en,
    input logic             done,
    input logic [CNT_W-1:0] remain,
    input logic [TOT_W-1:0] total,
    input logic             start_req,
    input logic [CNT_W-1:0] step_val
);

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dut_en |=> (remain == $past(remain) - CNT_W'(1)));

    assert_load_clears_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dut_en && start_req && (step_val != '0)) |=>
            (dut_en && !done && (remain == $past(step_val))));

    assert_done_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dut_en) |-> done);

    assert_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!dut_en && start_req && (step_val == '0)) |=> (!dut_en && $stable(done)));

    assert_tally_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dut_en |=> (total == $past(total) + TOT_W'(1)));

    assert_tally_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dut_en |=> $stable(total));

endmodule

bind sync_step_top sync_step_chk #(
    .CNT_W(CNT_W),
    .TOT_W(TOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dut_en   (dut_en),
    .done     (done),
    .remain   (remain),
    .total    (total),
    .start_req(start_req),
    .step_val (step_val)
);

// File: tb/tb_sync_step_top.sv
`timescale 1ns/1ps
module tb_sync_step_top;

    localparam int CNT_W  = 8;
    localparam int TOT_W  = 32;
    localparam int DATA_W = 32;
    localparam int NVEC   = 6;
    // stimulus: step length; expected burst length equals step (R3)
    localparam int unsigned STEPS [NVEC] = '{1, 2, 7, 3, 255, 12};
    localparam int unsigned EXPLEN[NVEC] = '{1, 2, 7, 3, 255, 12};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [1:0]        host_addr = 2'd0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              dut_en;

    int n_chk = 0;
    int n_bad = 0;
    longint unsigned exp_total = 0;

    always #2.5 clk = ~clk;

    sync_step_top #(
        .CNT_W (CNT_W),
        .TOT_W (TOT_W),
        .DATA_W(DATA_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .dut_en    (dut_en)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        host_wr    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] v);
        host_addr = a;
        #0.5;
        v = host_rdata;
    endtask

    task automatic count_burst(output int n);
        n = 0;
        while (dut_en && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (dut_en && guard < 2000) begin
            guard++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] t0;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 en", dut_en, 0);
        rd(2'd2, v); check("R1 status", v, 0);
        rd(2'd3, v); check("R1 total", v, 0);
        rd(2'd0, v); check("R1 step", v, 0);

        // R2 step readback, upper bits dropped
        wr(2'd0, 32'hABCD_0135);
        rd(2'd0, v); check("R2 step readback", v, 32'h35);

        // vector table: R3/R4/R5/R8
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, STEPS[i]);
            wr(2'd1, 32'h1);
            rd(2'd2, v); check("R4 busy during burst", v, 1);
            count_burst(n);
            check("R3 burst length", n, EXPLEN[i]);
            exp_total += EXPLEN[i];
            rd(2'd2, v); check("R5 done after burst", v, 2);
            rd(2'd3, v); check("R8 total", v, exp_total);
        end

        // R6 zero step ignored, done stays set
        wr(2'd0, 0);
        wr(2'd1, 32'h1);
        repeat (3) begin
            check("R6 no enable", dut_en, 0);
            @(negedge clk);
        end
        rd(2'd2, v); check("R6 done kept", v, 2);
        rd(2'd3, v); check("R6 total unchanged", v, exp_total);

        // R9 command with bit0 clear
        wr(2'd0, 5);
        wr(2'd1, 32'hFFFF_FFFE);
        repeat (3) begin
            check("R9 no enable", dut_en, 0);
            @(negedge clk);
        end
        rd(2'd2, v); check("R9 status", v, 2);

        // R7 go during burst ignored
        wr(2'd0, 6);
        rd(2'd3, t0);
        wr(2'd1, 32'h1);
        rd(2'd2, v); check("R5 done cleared by go", v, 1);
        wr(2'd1, 32'h1);
        wait_idle();
        rd(2'd3, v); check("R7 burst length kept", v - t0, 6);
        exp_total += 6;

        // R10 step rewrite during burst
        wr(2'd0, 4);
        rd(2'd3, t0);
        wr(2'd1, 32'h1);
        wr(2'd0, 9);
        wait_idle();
        rd(2'd3, v); check("R10 current burst", v - t0, 4);
        wr(2'd1, 32'h1);
        count_burst(n);
        check("R10 next burst uses new step", n, 9);
        exp_total += 13;
        rd(2'd3, v); check("R8 final total", v, exp_total);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule